// File: doc/BRIEF.md
# Four-Lane Round-Robin Sample Capture Buffer

This block records a burst of converter samples that arrive at up to one per clock. Each accepted sample that passes the rate divider is handed to the next of several lanes in strict rotation. Each lane therefore runs at a fraction of the input rate and parks its samples in a small FIFO of its own. A merge stage visits the lanes in the same rotation and writes every sample it removes into a dual-port RAM. The write address starts at zero, so the RAM ends up holding the capture in arrival order. A processor reads the second RAM port, and a small register set, through a simple synchronous bus.

Software programs a rate divider N and a sample count, then issues an arm command. After arming, the first accepted input sample is stored, and then every N-th one after it. When the RAM holds the programmed number of samples, the capture stops and a done flag is raised. If a lane FIFO is ever full when a sample reaches it, that sample is dropped and a sticky overflow flag is set. The merge stage removes at most one sample every `MERGE_II` cycles. At full input rate, a loss-free capture therefore needs a divider of at least `MERGE_II`.

The input is a valid/ready stream with no back-pressure. A sample transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is a report of whether the block is still taking samples; it never asks the source to hold. A sample offered while `in_ready` is low is lost. The source keeps streaming regardless of `in_ready`.

Top module: `sample_lane_capture`

## Requirements
- R1: After reset, the status register reads 0 (busy, done and overflow all clear), the divider register reads 1, the count register reads 2^ADDR_W, and `in_ready` is low.
- R2: A bus write to register 0 with bit 0 set arms a capture. From the next cycle, busy=1 and done=0, all lane FIFOs are emptied, the lane rotation restarts at lane 0, and the next RAM write goes to address 0.
- R3: Stored samples go to lanes 0, 1, …, LANES-1 and then back to lane 0. At most one lane receives a sample per cycle, and the merge stage drains the lanes in the same order.
- R4: RAM word i holds the i-th stored sample of the current capture, for i counted from 0. The RAM write address rises by exactly one per merged sample.
- R5: With divider N, the first accepted sample after arming is stored, and then every N-th accepted sample. A divider of 0 acts as 1. Only stored samples advance the lane rotation.
- R6: The capture length is min(count register, 2^ADDR_W). Once that many samples sit in the RAM, busy=0 and done=1, and no further RAM write or lane push occurs. A length of 0 finishes with no write at all.
- R7: `in_ready` is high only while busy and while fewer than the capture length of samples have been stored. Samples with `in_valid` high while `in_ready` is low leave the RAM unchanged.
- R8: A sample sent to a full lane FIFO is dropped and sets the overflow flag (status bit 2). If a set and a clear arrive in the same cycle, the set wins. The flag stays set, including across arming, until a write to register 0 with bit 1 set. Register-0 writes with bit 1 clear leave it alone.
- R9: A bus read returns data in the cycle after the request. Addresses with bit ADDR_W clear read RAM word bus_addr[ADDR_W-1:0], zero-extended. With bit ADDR_W set, the low two bits select the register: 0 is status {overflow, done, busy} in bits 2..0, 1 is the divider, 2 is the count, and 3 reads 0.
- R10: Writes to registers 1 and 2 set the divider and count, and those values read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for stream, lanes, RAM and bus |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_ready | output | 1 | Block is taking samples; no back-pressure |
| in_data | input | DATA_W | Input sample |
| bus_en | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W+1 | Bit ADDR_W selects registers, otherwise RAM word address |
| bus_wdata | input | DIV_W | Register write data |
| bus_rdata | output | BUS_W | Read data, one cycle after the request |

## Verification
The bound checker watches the properties that hold on every cycle:
- at most one lane push per cycle, in rotation order;
- the first RAM write after arming goes to address zero, and each later write goes one address higher;
- no pushes or writes once done is set;
- busy and done are never both set;
- done and overflow hold their values;
- `in_ready` stays low while idle.

Other behaviours need the bench's scenarios, which read the RAM back and compare it with a scoreboard of the expected stored samples:
- arrival order in the RAM;
- the divider's choice of samples, including a divider of zero;
- clamping of the capture length, and a zero length;
- samples offered after done;
- how overflow is provoked and cleared.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam logic [1:0] REG_CTRL  = 2'd0;
  localparam logic [1:0] REG_DIV   = 2'd1;
  localparam logic [1:0] REG_COUNT = 2'd2;

  localparam int CTRL_ARM = 0;
  localparam int CTRL_CLR = 1;

  localparam int ST_BUSY = 0;
  localparam int ST_DONE = 1;
  localparam int ST_OVF  = 2;
endpackage

// File: rtl/lane_fifo.sv
module lane_fifo #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wr_ptr, rd_ptr;
  logic             full;

  assign empty    = (wr_ptr == rd_ptr);
  assign full     = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign overflow = push && full;
  assign dout     = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push && !full) begin
        mem[wr_ptr[AW-1:0]] <= din;
        wr_ptr <= wr_ptr + 1'b1;
      end
      if (pop && !empty) begin
        rd_ptr <= rd_ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lane_splitter.sv
module lane_splitter #(
  parameter int DATA_W = 12,
  parameter int LANES  = 4,
  parameter int DIV_W  = 8,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              enable,
  input  logic [CNT_W-1:0]  target,
  input  logic [DIV_W-1:0]  divider,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic [LANES-1:0]  lane_push,
  output logic [DATA_W-1:0] lane_data
);
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LANE_W-1:0] cur;
  logic [DIV_W-1:0]  phase;
  logic [DIV_W-1:0]  div_eff;
  logic [CNT_W-1:0]  issued;
  logic              accept, store;

  assign div_eff   = (divider == '0) ? DIV_W'(1) : divider;
  assign in_ready  = enable && (issued < target);
  assign accept    = in_valid && in_ready && !restart;
  assign store     = accept && (phase == '0);
  assign lane_data = in_data;

  for (genvar g = 0; g < LANES; g++) begin : g_push
    assign lane_push[g] = store && (cur == LANE_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cur    <= '0;
      phase  <= '0;
      issued <= '0;
    end else if (accept) begin
      phase <= (phase == div_eff - 1'b1) ? '0 : phase + 1'b1;
      if (store) begin
        issued <= issued + 1'b1;
        cur    <= (cur == LANE_W'(LANES - 1)) ? '0 : cur + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lane_merger.sv
module lane_merger #(
  parameter int DATA_W   = 12,
  parameter int LANES    = 4,
  parameter int ADDR_W   = 6,
  parameter int CNT_W    = 7,
  parameter int MERGE_II = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    restart,
  input  logic                    enable,
  input  logic [CNT_W-1:0]        target,
  input  logic [LANES-1:0]        lane_empty,
  input  logic [LANES*DATA_W-1:0] lane_dout,
  output logic [LANES-1:0]        lane_pop,
  output logic                    ram_we,
  output logic [ADDR_W-1:0]       ram_waddr,
  output logic [DATA_W-1:0]       ram_wdata,
  output logic                    finished
);
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int TICK_W = (MERGE_II > 1) ? $clog2(MERGE_II) : 1;

  logic [LANE_W-1:0] cur;
  logic [TICK_W-1:0] tick;
  logic [CNT_W-1:0]  written;
  logic              issue;

  assign finished  = (written == target);
  assign issue     = enable && !restart && !finished && (tick == '0) && !lane_empty[cur];
  assign ram_we    = issue;
  assign ram_waddr = written[ADDR_W-1:0];
  assign ram_wdata = lane_dout[cur*DATA_W +: DATA_W];

  for (genvar g = 0; g < LANES; g++) begin : g_pop
    assign lane_pop[g] = issue && (cur == LANE_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cur     <= '0;
      tick    <= '0;
      written <= '0;
    end else if (enable) begin
      tick <= (tick == TICK_W'(MERGE_II - 1)) ? '0 : tick + 1'b1;
      if (issue) begin
        written <= written + 1'b1;
        cur     <= (cur == LANE_W'(LANES - 1)) ? '0 : cur + 1'b1;
      end
    end
  end
endmodule

// File: rtl/capture_ram.sv
module capture_ram #(
  parameter int WIDTH  = 12,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sample_lane_capture.sv
module sample_lane_capture
  import cap_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int LANES      = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int ADDR_W     = 6,
  parameter int DIV_W      = 8,
  parameter int BUS_W      = 16,
  parameter int MERGE_II   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W:0]   bus_addr,
  input  logic [DIV_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata
);
  localparam int CNT_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  // register file and control
  logic             reg_wr, reg_rd;
  logic             arm_pulse, clr_pulse;
  logic [DIV_W-1:0] div_reg;
  logic [CNT_W-1:0] cnt_reg, target;
  logic             cap_busy, cap_done, ovf_flag;
  logic             merge_fin;

  assign reg_wr    = bus_en && bus_we && bus_addr[ADDR_W];
  assign reg_rd    = bus_en && !bus_we;
  assign arm_pulse = reg_wr && (bus_addr[1:0] == REG_CTRL) && bus_wdata[CTRL_ARM];
  assign clr_pulse = reg_wr && (bus_addr[1:0] == REG_CTRL) && bus_wdata[CTRL_CLR];
  assign target    = (cnt_reg > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : cnt_reg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_reg <= DIV_W'(1);
      cnt_reg <= CNT_W'(DEPTH);
    end else if (reg_wr) begin
      if (bus_addr[1:0] == REG_DIV)   div_reg <= bus_wdata;
      if (bus_addr[1:0] == REG_COUNT) cnt_reg <= bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_busy <= 1'b0;
      cap_done <= 1'b0;
    end else if (arm_pulse) begin
      cap_busy <= 1'b1;
      cap_done <= 1'b0;
    end else if (cap_busy && merge_fin) begin
      cap_busy <= 1'b0;
      cap_done <= 1'b1;
    end
  end

  // lanes
  logic [LANES-1:0]        lane_push, lane_pop, lane_empty, lane_ovf;
  logic [DATA_W-1:0]       lane_data;
  logic [LANES*DATA_W-1:0] lane_dout;

  always_ff @(posedge clk) begin
    if (!rst_n)        ovf_flag <= 1'b0;
    else if (|lane_ovf) ovf_flag <= 1'b1;
    else if (clr_pulse) ovf_flag <= 1'b0;
  end

  lane_splitter #(
    .DATA_W(DATA_W), .LANES(LANES), .DIV_W(DIV_W), .CNT_W(CNT_W)
  ) u_split (
    .clk(clk), .rst_n(rst_n), .restart(arm_pulse), .enable(cap_busy),
    .target(target), .divider(div_reg), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .lane_push(lane_push), .lane_data(lane_data)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(arm_pulse),
      .push(lane_push[g]), .din(lane_data),
      .pop(lane_pop[g]), .dout(lane_dout[g*DATA_W +: DATA_W]),
      .empty(lane_empty[g]), .overflow(lane_ovf[g])
    );
  end

  // merge into RAM
  logic              ram_we;
  logic [ADDR_W-1:0] ram_waddr;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;

  lane_merger #(
    .DATA_W(DATA_W), .LANES(LANES), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MERGE_II(MERGE_II)
  ) u_merge (
    .clk(clk), .rst_n(rst_n), .restart(arm_pulse), .enable(cap_busy),
    .target(target), .lane_empty(lane_empty), .lane_dout(lane_dout),
    .lane_pop(lane_pop), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata), .finished(merge_fin)
  );

  capture_ram #(.WIDTH(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(reg_rd), .raddr(bus_addr[ADDR_W-1:0]), .rdata(ram_rdata)
  );

  // read path: registers and RAM both answer one cycle later
  logic             rd_reg_sel;
  logic [BUS_W-1:0] rd_reg_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_reg_sel <= 1'b0;
      rd_reg_val <= '0;
    end else if (reg_rd) begin
      rd_reg_sel <= bus_addr[ADDR_W];
      case (bus_addr[1:0])
        REG_CTRL: begin
          rd_reg_val <= '0;
          rd_reg_val[ST_BUSY] <= cap_busy;
          rd_reg_val[ST_DONE] <= cap_done;
          rd_reg_val[ST_OVF]  <= ovf_flag;
        end
        REG_DIV:   rd_reg_val <= BUS_W'(div_reg);
        REG_COUNT: rd_reg_val <= BUS_W'(cnt_reg);
        default:   rd_reg_val <= '0;
      endcase
    end
  end

  assign bus_rdata = rd_reg_sel ? rd_reg_val : BUS_W'(ram_rdata);
endmodule

// File: rtl/capture_checks.sv
module capture_checks #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm,
  input logic              clr,
  input logic              busy,
  input logic              done,
  input logic              ovf,
  input logic              in_ready,
  input logic [LANES-1:0]  lane_push,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_waddr
);
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LANE_W-1:0] exp_lane;
  logic [ADDR_W-1:0] last_addr;
  logic              have_last;

  always_ff @(posedge clk) begin
    if (!rst_n || arm) begin
      exp_lane  <= '0;
      have_last <= 1'b0;
      last_addr <= '0;
    end else begin
      if (|lane_push)
        exp_lane <= (exp_lane == LANE_W'(LANES - 1)) ? '0 : exp_lane + 1'b1;
      if (ram_we) begin
        have_last <= 1'b1;
        last_addr <= ram_waddr;
      end
    end
  end

  p_one_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_push));
  p_rotation_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_push) |-> lane_push[exp_lane]);
  p_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !have_last) |-> (ram_waddr == '0));
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && have_last) |-> (ram_waddr == ADDR_W'(last_addr + 1'b1)));
  p_quiet_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ram_we && lane_push == '0));
  p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done);
  p_busy_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  p_ovf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf);
  p_idle_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready);
endmodule

bind sample_lane_capture capture_checks #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm_pulse), .clr(clr_pulse),
  .busy(cap_busy), .done(cap_done), .ovf(ovf_flag), .in_ready(in_ready),
  .lane_push(lane_push), .ram_we(ram_we), .ram_waddr(ram_waddr)
);

// File: tb/sample_lane_capture_test.sv
module sample_lane_capture_test;
  localparam int CLK_PERIOD = 8;
  localparam int DATA_W = 12;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int REGB   = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic              bus_en = 1'b0, bus_we = 1'b0;
  logic [ADDR_W:0]   bus_addr = '0;
  logic [7:0]        bus_wdata = '0;
  logic [15:0]       bus_rdata;

  sample_lane_capture uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  logic [DATA_W-1:0] exp_q[$];
  logic [DATA_W-1:0] snap[$];
  int m_div, m_target, m_stored, m_phase;
  bit m_armed = 0;

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic bus_write(int addr, int data);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = (ADDR_W+1)'(addr); bus_wdata = 8'(data);
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic bus_read(int addr, output logic [15:0] val);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = (ADDR_W+1)'(addr);
    @(negedge clk);
    val = bus_rdata;
    bus_en = 0;
  endtask

  task automatic arm_capture(int div, int count);
    bus_write(REGB + 1, div);
    bus_write(REGB + 2, count);
    bus_write(REGB + 0, 1);
    m_div = (div == 0) ? 1 : div;
    m_target = (count > DEPTH) ? DEPTH : count;
    m_stored = 0; m_phase = 0; m_armed = 1;
    exp_q.delete();
  endtask

  // driver: applies samples and pushes the expected stored ones
  task automatic drive(int n, int base, bit gaps, string req);
    for (int i = 0; i < n; i++) begin
      bit v;
      bit exp_ready;
      @(negedge clk);
      v = gaps ? ((i % 3) != 1) : 1'b1;
      in_valid = v;
      in_data = DATA_W'(base + i * 37);
      exp_ready = m_armed && (m_stored < m_target);
      check(req, "in_ready", 32'(in_ready), 32'(exp_ready));
      if (v && exp_ready) begin
        if (m_phase == 0) begin
          exp_q.push_back(in_data);
          m_stored++;
        end
        m_phase = (m_phase + 1 == m_div) ? 0 : m_phase + 1;
      end
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wait_done(string req);
    logic [15:0] st;
    st = '0;
    for (int k = 0; k < 500; k++) begin
      bus_read(REGB, st);
      if (st[1]) break;
    end
    check(req, "status after capture", 32'(st), 32'h2);
    m_armed = 0;
  endtask

  // monitor: reads the RAM and pops the scoreboard
  task automatic check_ram(int n, string req);
    logic [15:0] v;
    snap.delete();
    for (int i = 0; i < n; i++) begin
      bus_read(i, v);
      snap.push_back(v[DATA_W-1:0]);
      if (exp_q.size() == 0) begin
        check(req, "scoreboard underrun", 32'(i), 32'(n));
      end else begin
        check(req, $sformatf("ram[%0d]", i), 32'(v), 32'(exp_q.pop_front()));
      end
    end
    check(req, "scoreboard leftover", 32'(exp_q.size()), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1", "in_ready", 32'(in_ready), 0);
    bus_read(REGB, v);     check("R1", "status", 32'(v), 0);
    bus_read(REGB + 1, v); check("R1", "divider", 32'(v), 1);
    bus_read(REGB + 2, v); check("R1", "count", 32'(v), DEPTH);
    bus_read(REGB + 3, v); check("R9", "reserved reg", 32'(v), 0);

    // R10 register readback
    bus_write(REGB + 1, 5);  bus_read(REGB + 1, v); check("R10", "divider", 32'(v), 5);
    bus_write(REGB + 2, 37); bus_read(REGB + 2, v); check("R10", "count", 32'(v), 37);

    // R2/R3/R4: divider 1, short burst
    arm_capture(1, 12);
    bus_read(REGB, v); check("R2", "status after arm", 32'(v), 1);
    drive(16, 100, 0, "R7");
    wait_done("R6");
    check_ram(12, "R4");
    // R7: samples after done change nothing
    drive(6, 3000, 0, "R7");
    for (int i = 0; i < 12; i++) begin
      bus_read(i, v);
      check("R7", $sformatf("ram[%0d] after done", i), 32'(v), 32'(snap[i]));
    end
    bus_read(REGB, v); check("R6", "done held", 32'(v), 2);

    // R5: divider 3 with gaps in the stream
    arm_capture(3, 10);
    drive(50, 500, 1, "R5");
    wait_done("R5");
    check_ram(10, "R5");

    // R5: divider 0 acts as 1
    arm_capture(0, 8);
    drive(10, 1200, 0, "R5");
    wait_done("R5");
    check_ram(8, "R5");

    // R6: zero length
    arm_capture(1, 0);
    repeat (2) @(negedge clk);
    check("R6", "in_ready zero length", 32'(in_ready), 0);
    wait_done("R6");

    // R6: length clamped to RAM depth, R3 across many rotations
    arm_capture(2, 100);
    drive(140, 2000, 0, "R3");
    wait_done("R6");
    check_ram(DEPTH, "R3");
    bus_read(REGB, v); check("R8", "no overflow at divider 2", 32'(v[2]), 0);

    // R8: overflow at full rate
    arm_capture(1, DEPTH);
    drive(DEPTH + 4, 40, 0, "R7");
    repeat (10) @(negedge clk);
    bus_read(REGB, v); check("R8", "overflow set", 32'(v[2]), 1);
    bus_write(REGB + 0, 0);
    bus_read(REGB, v); check("R8", "overflow kept on plain write", 32'(v[2]), 1);
    bus_write(REGB + 0, 2);
    bus_read(REGB, v); check("R8", "overflow cleared", 32'(v[2]), 0);

    // R2: re-arm after overflow flushes lanes and restarts at address 0
    arm_capture(2, 12);
    drive(30, 777, 0, "R2");
    wait_done("R2");
    check_ram(12, "R2");

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule